// File: doc/BRIEF.md
# Bit-Serial Receive Buffer with Interrupt Status Port

This block sits behind a data demodulator and clock-recovery stage. Each recovered bit arrives with a one-cycle valid strobe. The bit is stored in a 64-entry, bit-granular first-in first-out buffer, but only while the host has enabled capture. Three kinds of event share one active-low interrupt line: a full buffer, a pulse from a wake-up timer, and a pulse from a supply-voltage comparator. A dropped bit sets an overflow flag, which also drives the line.

The host reads the block over a four-wire serial port with the clock idle low. It samples data-out on rising clock edges. Pulling chip select low captures a four-bit status snapshot. That snapshot shifts out first, and the stored bits, oldest first, follow it. The host chooses, one bit at a time, whether the bit just read is removed from the buffer. Removal is refused while the reference oscillator is reported off.

The receive input has a valid strobe but no ready signal. There is no back-pressure: a valid bit is either stored or, if the buffer is full, dropped and recorded as an overflow. All serial-port inputs pass through two register stages before use, so the host's serial clock must be much slower than the block clock.

Top module: `rxf_top`

## Requirements
- R1: The buffer holds at most 64 bits and returns them on the serial port in arrival order, oldest first.
- R2: A bit presented with `rx_valid` high is stored only when `fifo_en` is 1; otherwise it is ignored.
- R3: While 64 bits are held, the full status bit is 1 and `irq_n` is low. The full bit returns to 0 as soon as one bit is removed.
- R4: A one-cycle pulse on `wkup_evt` or `lowbat_evt` latches a flag that holds `irq_n` low, starting in the next cycle.
- R5: After chip select falls, the first four bits on `spi_miso` are a status snapshot taken when the select was seen low, MSB first: bit 3 full, bit 2 overflow, bit 1 wake-up, bit 0 low supply. A new bit appears after each rising serial clock.
- R6: After the status bits, `spi_miso` shows the oldest stored bit, or 0 when the buffer is empty. A rising serial clock with `spi_mosi` high removes that bit. With `spi_mosi` low, the bit stays in place.
- R7: While `osc_on` is 0, the data phase drives `spi_miso` to 0 and removes no bits.
- R8: When chip select rises after all four status bits were clocked, the overflow, wake-up and low-supply flags that were 1 in the snapshot clear. A read ended earlier clears nothing, and an event arriving during the read stays latched.
- R9: A valid bit that arrives while the buffer is full is dropped and sets the overflow flag.
- R10: After reset `irq_n` is high and `spi_miso` is 0. `spi_miso` stays 0 while chip select is high. Serial-port inputs take effect on the third clock edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Recovered data bit |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_bit` |
| fifo_en | input | 1 | Capture enable for the buffer |
| osc_on | input | 1 | Reference oscillator running; gates readout |
| wkup_evt | input | 1 | Wake-up timer timeout pulse |
| lowbat_evt | input | 1 | Low supply detection pulse |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Host data in; 1 removes the bit being read |
| spi_miso | output | 1 | Serial read data |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The hardest state to reach is the last slot of a full buffer being hit by an incoming bit while an overflow flag, an event flag and a partially clocked status read all interact. The stimulus fills all 64 slots and pushes past them. It then aborts one status read early and fires a low-supply pulse in the middle of another. This shows that only flags captured in a completed snapshot clear. A reference model with a queue tracks the synchronizer delays and is compared with `spi_miso` and `irq_n` on every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // status word, MSB shifted out first
  typedef struct packed {
    logic full;
    logic ovf;
    logic wake;
    logic lowbat;
  } rxf_stat_t;

  localparam int STAT_W = $bits(rxf_stat_t);
endpackage

// File: rtl/rxf_bit_fifo.sv
module rxf_bit_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          din,
  input  logic          pop,
  output logic          head,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          empty
);
  logic [DEPTH-1:0] store_q;
  logic [AW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);
  assign head  = store_q[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
    end else begin
      if (push) begin
        store_q[wr_ptr] <= din;
        wr_ptr          <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/rxf_event_latch.sv
module rxf_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_set,
  input  logic wake_set,
  input  logic lowbat_set,
  input  logic ovf_clr,
  input  logic wake_clr,
  input  logic lowbat_clr,
  output logic ovf_q,
  output logic wake_q,
  output logic lowbat_q
);
  // a set in the same cycle as a clear wins, so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q    <= 1'b0;
      wake_q   <= 1'b0;
      lowbat_q <= 1'b0;
    end else begin
      ovf_q    <= ovf_set    | (ovf_q    & ~ovf_clr);
      wake_q   <= wake_set   | (wake_q   & ~wake_clr);
      lowbat_q <= lowbat_set | (lowbat_q & ~lowbat_clr);
    end
  end
endmodule

// File: rtl/rxf_spi_port.sv
module rxf_spi_port #(
  parameter int HDR_BITS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int PW = $clog2(HDR_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  output logic          sel_active,
  output logic          sel_start,
  output logic          sel_end,
  output logic          bit_rise,
  output logic          mosi_s,
  output logic          data_phase,
  output logic [PW-1:0] phase
);
  logic [SYNC_STAGES-1:0] sck_s, cs_s, mo_s;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      mo_s  <= '0;
      cs_s  <= '1;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_s <= {sck_s[SYNC_STAGES-2:0], spi_sck};
      cs_s  <= {cs_s[SYNC_STAGES-2:0], spi_cs_n};
      mo_s  <= {mo_s[SYNC_STAGES-2:0], spi_mosi};
      sck_d <= sck_s[SYNC_STAGES-1];
      cs_d  <= cs_s[SYNC_STAGES-1];
    end
  end

  assign sel_active = ~cs_d;
  assign sel_start  = ~cs_s[SYNC_STAGES-1] & cs_d;
  assign sel_end    =  cs_s[SYNC_STAGES-1] & ~cs_d;
  assign bit_rise   =  sck_s[SYNC_STAGES-1] & ~sck_d & sel_active;
  assign mosi_s     =  mo_s[SYNC_STAGES-1];
  assign data_phase = (phase == PW'(HDR_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       phase <= '0;
    else if (sel_start)               phase <= '0;
    else if (bit_rise && !data_phase) phase <= phase + 1'b1;
  end
endmodule

// File: rtl/rxf_top.sv
module rxf_top #(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic rx_valid,
  input  logic fifo_en,
  input  logic osc_on,
  input  logic wkup_evt,
  input  logic lowbat_evt,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic irq_n
);
  import rxf_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(STAT_W + 1);

  logic          fifo_full, fifo_empty, fifo_head;
  logic [CW-1:0] fill_cnt;
  logic          ovf_flag, wake_flag, lowbat_flag;
  logic          sel_active, sel_start, sel_end, bit_rise, mosi_s, data_phase;
  logic [PW-1:0] phase;
  logic          push, pop, drop, snap_clr;
  rxf_stat_t     stat_now, snap_q;
  logic [STAT_W-1:0] snap_shift;

  assign push = rx_valid & fifo_en & ~fifo_full;
  assign drop = rx_valid & fifo_en &  fifo_full;
  assign pop  = bit_rise & data_phase & mosi_s & osc_on & ~fifo_empty;

  rxf_bit_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(rx_bit), .pop(pop),
    .head(fifo_head), .fill(fill_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  rxf_spi_port #(.HDR_BITS(STAT_W), .SYNC_STAGES(2)) u_port (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .sel_active(sel_active), .sel_start(sel_start),
    .sel_end(sel_end), .bit_rise(bit_rise), .mosi_s(mosi_s),
    .data_phase(data_phase), .phase(phase)
  );

  // flags clear only after a complete status word went out
  assign snap_clr = sel_end & data_phase;

  rxf_event_latch u_evt (
    .clk(clk), .rst_n(rst_n),
    .ovf_set(drop), .wake_set(wkup_evt), .lowbat_set(lowbat_evt),
    .ovf_clr(snap_clr & snap_q.ovf),
    .wake_clr(snap_clr & snap_q.wake),
    .lowbat_clr(snap_clr & snap_q.lowbat),
    .ovf_q(ovf_flag), .wake_q(wake_flag), .lowbat_q(lowbat_flag)
  );

  assign stat_now = '{full: fifo_full, ovf: ovf_flag, wake: wake_flag, lowbat: lowbat_flag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (sel_start) snap_q <= stat_now;
  end

  assign snap_shift = snap_q << phase;

  always_comb begin
    if (!sel_active)     spi_miso = 1'b0;
    else if (!data_phase) spi_miso = snap_shift[STAT_W-1];
    else                  spi_miso = osc_on & ~fifo_empty & fifo_head;
  end

  assign irq_n = ~(fifo_full | ovf_flag | wake_flag | lowbat_flag);
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          fifo_en,
  input logic          osc_on,
  input logic          wkup_evt,
  input logic          lowbat_evt,
  input logic          spi_cs_n,
  input logic          spi_miso,
  input logic          irq_n,
  input logic [CW-1:0] fill_cnt,
  input logic          ovf_flag
);
  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  assert_disabled_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> fill_cnt <= $past(fill_cnt));

  assert_full_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt == CW'(DEPTH) |-> !irq_n);

  assert_event_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wkup_evt || lowbat_evt) |=> !irq_n);

  assert_osc_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_on |=> fill_cnt >= $past(fill_cnt));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fifo_en && fill_cnt == CW'(DEPTH)) |=> (ovf_flag && fill_cnt == CW'(DEPTH)));

  assert_idle_miso_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);
endmodule

bind rxf_top rxf_checker #(.DEPTH(DEPTH)) u_rxf_checker (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .fifo_en(fifo_en),
  .osc_on(osc_on), .wkup_evt(wkup_evt), .lowbat_evt(lowbat_evt),
  .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .irq_n(irq_n),
  .fill_cnt(fill_cnt), .ovf_flag(ovf_flag)
);

// File: tb/test_rxf_top.sv
module test_rxf_top;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic rx_bit = 1'b0, rx_valid = 1'b0, fifo_en = 1'b0, osc_on = 1'b1;
  logic wkup_evt = 1'b0, lowbat_evt = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, irq_n;

  rxf_top #(.DEPTH(DEPTH)) i_rxf_top (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .fifo_en(fifo_en), .osc_on(osc_on), .wkup_evt(wkup_evt),
    .lowbat_evt(lowbat_evt), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq_n(irq_n)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit mq[$];
  bit m_ovf, m_wk, m_lb;
  bit [3:0] m_snap;
  int m_ph;
  bit m_s0, m_s1, m_sd, m_c0, m_c1, m_cd, m_m0, m_m1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_ovf = 0; m_wk = 0; m_lb = 0; m_snap = 0; m_ph = 0;
      m_s0 = 0; m_s1 = 0; m_sd = 0; m_m0 = 0; m_m1 = 0;
      m_c0 = 1; m_c1 = 1; m_cd = 1;
    end else begin
      bit full, rise, fall, csr, pop, push, ov;
      full = (mq.size() == DEPTH);
      rise = m_s1 && !m_sd && !m_cd;
      fall = !m_c1 && m_cd;
      csr  = m_c1 && !m_cd;
      pop  = rise && m_ph == 4 && m_m1 && osc_on && mq.size() > 0;
      push = rx_valid && fifo_en && !full;
      ov   = rx_valid && fifo_en && full;
      if (csr && m_ph == 4) begin
        if (m_snap[2]) m_ovf = 0;
        if (m_snap[1]) m_wk = 0;
        if (m_snap[0]) m_lb = 0;
      end
      if (fall) begin
        m_snap = {full, m_ovf, m_wk, m_lb};
        m_ph = 0;
      end else if (rise && m_ph < 4) m_ph++;
      if (ov) m_ovf = 1;
      if (wkup_evt) m_wk = 1;
      if (lowbat_evt) m_lb = 1;
      if (pop) void'(mq.pop_front());
      if (push) mq.push_back(rx_bit);
      m_sd = m_s1; m_s1 = m_s0; m_s0 = spi_sck;
      m_cd = m_c1; m_c1 = m_c0; m_c0 = spi_cs_n;
      m_m1 = m_m0; m_m0 = spi_mosi;
    end
  end

  // compare every cycle, away from both clock edges
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      bit exp_miso;
      if (m_cd) exp_miso = 0;
      else if (m_ph < 4) exp_miso = m_snap[3 - m_ph];
      else exp_miso = osc_on && mq.size() > 0 && mq[0];
      if (m_cd) check("R10 miso idle", spi_miso, exp_miso);
      else if (m_ph < 4) check("R5 status bit", spi_miso, exp_miso);
      else check("R6 data bit", spi_miso, exp_miso);
      check("R4 irq_n", irq_n, !(mq.size() == DEPTH || m_ovf || m_wk || m_lb));
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_bit(input logic b);
    @(negedge clk);
    rx_bit = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic spi_read(input int nbits, input logic mo, output logic [127:0] got);
    got = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    idle(5);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = mo;
      idle(4);
      got = {got[126:0], spi_miso};
      spi_sck = 1'b1;
      idle(4);
      spi_sck = 1'b0;
    end
    idle(4);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    idle(5);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=below limit", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] got, exp;
    logic [9:0] pat;
    pat = 10'b1011001110;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check("R10 irq_n after reset", irq_n, 1'b1);
    check("R10 miso after reset", spi_miso, 1'b0);

    // R2: capture disabled
    fifo_en = 1'b0;
    for (int i = 0; i < 5; i++) push_bit(1'b1);
    spi_read(10, 1'b1, got);
    check("R2 nothing stored while disabled", got, 128'd0);

    // R1 / R6: ordering and peek
    fifo_en = 1'b1;
    for (int i = 9; i >= 0; i--) push_bit(pat[i]);
    spi_read(7, 1'b0, got);
    check("R6 peek keeps head", got, {121'd0, 4'b0000, 3'b111});
    spi_read(14, 1'b1, got);
    check("R1 arrival order", got, {114'd0, 4'b0000, pat});

    // R3 / R9: full and overflow
    for (int i = 0; i < DEPTH; i++) push_bit(i % 3 == 0);
    idle(2);
    check("R3 irq on full", irq_n, 1'b0);
    for (int i = 0; i < 3; i++) push_bit(1'b0);
    spi_read(4, 1'b0, got);
    check("R9 overflow in status", got, 128'b1100);
    check("R3 irq stays while full", irq_n, 1'b0);

    // R7: oscillator off refuses readout
    osc_on = 1'b0;
    spi_read(8, 1'b1, got);
    check("R7 zeros with osc off, R8 overflow cleared", got, {120'd0, 4'b1000, 4'b0000});
    osc_on = 1'b1;
    spi_read(5, 1'b1, got);
    check("R7 nothing removed while off", got, {123'd0, 4'b1000, 1'b1});
    idle(2);
    check("R3 full clears after one removal", irq_n, 1'b1);

    // R4 / R8: events, aborted read, event during read
    pulse(wkup_evt);
    idle(1);
    check("R4 wake latches irq", irq_n, 1'b0);
    spi_read(2, 1'b0, got);
    check("R8 aborted read header", got, 128'b00);
    check("R8 aborted read clears nothing", irq_n, 1'b0);
    fork
      spi_read(4, 1'b0, got);
      begin idle(20); pulse(lowbat_evt); end
    join
    check("R5 wake bit in status", got, 128'b0010);
    check("R8 event during read survives", irq_n, 1'b0);
    spi_read(4, 1'b0, got);
    check("R8 low supply bit in status", got, 128'b0001);
    check("R8 flags cleared", irq_n, 1'b1);

    // R1: drain the remaining 63 bits
    exp = '0;
    for (int i = 1; i < DEPTH; i++) exp = {exp[126:0], (i % 3 == 0)};
    spi_read(4 + DEPTH - 1, 1'b1, got);
    check("R1 drain order", got, exp);
    spi_read(6, 1'b1, got);
    check("R6 empty reads zero", got, 128'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule